// File: doc/BRIEF.md
# Significand Square Root Estimator

This block produces a 32-bit integer estimate of the square root of a normalized 32-bit significand, for use inside a floating-point square root or reciprocal square root datapath that refines the estimate further. The caller presents the significand and the low bit of its exponent and pulses `start`. The block forms a linear seed from the top significand bits and corrects it with a small constant per 16-way index, one table per exponent parity. It then runs a Newton-style refinement and a final division.

Both divisions share one serial restoring divider (64-bit dividend, 32-bit divisor, one quotient bit per clock). In the even-parity case, a refined value that does not exceed the significand ends the operation after the first division. A significand whose top bit is clear is rejected at once and reported as illegal.

Top module: `sig_sqrt_est`

## Requirements
- R1: When `start` is sampled in idle with `sig_in[31]` = 0, the block raises `done` and `illegal` right after that same clock edge, and `root` is 0.
- R2: The correction constant is selected by `sig_in[30:27]`. With an odd exponent it is subtracted from 0x4000 + (a >> 17). With an even exponent it is subtracted from 0x8000 + (a >> 17). Every one of the 16 indices is used for each parity.
- R3: Odd exponent (`exp_odd` = 1), with seed s: z = ((a / s) << 14) + (s << 15), modulo 2^32. The result is the low 32 bits of ((a >> 1) << 31) / z, plus z >> 1. It lies within 2 of sqrt(a * 2^31).
- R4: Even exponent, not ending early: t = a / s + s. z = 0xFFFF8000 if t >= 0x20000, otherwise t << 15. The result is the low 32 bits of (a << 31) / z, plus z >> 1. It lies within 2 of sqrt(a * 2^32).
- R5: Even exponent with z <= a: the result is a shifted right by one with bit 31 copied, so bit 31 of `root` is 1. `done` follows 66 clock edges after the edge that sampled `start`.
- R6: A completed legal operation that does not end early raises `done` 132 clock edges after the edge that sampled `start`.
- R7: `busy` is high from acceptance until `done`. `done` is a one-cycle pulse. A `start` seen while busy is ignored, so the result belongs to the first operand.
- R8: `root` and `illegal` keep their values between completions.
- R9: While reset is asserted, `busy`, `done`, `illegal` and `root` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an estimate with the current operand |
| sig_in | input | 32 | Significand, must be at least 2^31 |
| exp_odd | input | 1 | Least significant bit of the exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last operand was below 2^31 |
| root | output | 32 | Square root estimate |

## Verification
Each result has a fixed due time, counted from the clock edge that samples `start`. A rejected operand completes on that same edge. An even-parity early exit completes 66 edges later, after one full division. Every other case completes 132 edges later, after two divisions. The bench drives inputs and samples outputs on falling edges, counts the falling edges until `done` is seen, and compares that count with the due time. It then compares `root` with a model built from the requirement formulas and with a real-valued square root, and the result must lie within 2 of the real value.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  localparam int SIG_W   = 32;
  localparam int DIV_W   = 2 * SIG_W;
  localparam int IDX_W   = 4;
  localparam int IDX_LSB = SIG_W - 1 - IDX_W;
  localparam int CORR_W  = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GO1,
    ST_WAIT1,
    ST_GO2,
    ST_WAIT2
  } sqe_state_e;

  // correction constants for odd exponent parity
  function automatic logic [CORR_W-1:0] corr_odd(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return 12'h004;
      4'd1:  return 12'h022;
      4'd2:  return 12'h05D;
      4'd3:  return 12'h0B1;
      4'd4:  return 12'h11D;
      4'd5:  return 12'h19F;
      4'd6:  return 12'h236;
      4'd7:  return 12'h2E0;
      4'd8:  return 12'h39C;
      4'd9:  return 12'h468;
      4'd10: return 12'h545;
      4'd11: return 12'h631;
      4'd12: return 12'h72B;
      4'd13: return 12'h832;
      4'd14: return 12'h946;
      default: return 12'hA67;
    endcase
  endfunction

  // correction constants for even exponent parity
  function automatic logic [CORR_W-1:0] corr_even(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return 12'hA2D;
      4'd1:  return 12'h8AF;
      4'd2:  return 12'h75A;
      4'd3:  return 12'h629;
      4'd4:  return 12'h51A;
      4'd5:  return 12'h429;
      4'd6:  return 12'h356;
      4'd7:  return 12'h29E;
      4'd8:  return 12'h200;
      4'd9:  return 12'h179;
      4'd10: return 12'h109;
      4'd11: return 12'h0AF;
      4'd12: return 12'h068;
      4'd13: return 12'h034;
      4'd14: return 12'h012;
      default: return 12'h002;
    endcase
  endfunction
endpackage

// File: rtl/sqe_seed.sv
module sqe_seed
  import sqe_pkg::*;
#(
  parameter int W = SIG_W
) (
  input  logic [W-1:0] sig,
  input  logic         odd,
  output logic [W-1:0] seed
);
  localparam int HI_SHIFT = 17;
  localparam logic [W-1:0] BASE_ODD  = W'(32'h4000);
  localparam logic [W-1:0] BASE_EVEN = W'(32'h8000);

  logic [IDX_W-1:0]  idx;
  logic [CORR_W-1:0] corr;

  always_comb begin
    idx  = sig[IDX_LSB +: IDX_W];
    corr = odd ? corr_odd(idx) : corr_even(idx);
    seed = (odd ? BASE_ODD : BASE_EVEN) + (sig >> HI_SHIFT) - W'(corr);
  end
endmodule

// File: rtl/sqe_refine.sv
module sqe_refine
  import sqe_pkg::*;
#(
  parameter int W = SIG_W
) (
  input  logic         odd,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] quot,
  output logic [W-1:0] z,
  output logic [W-1:0] sig_next,
  output logic         early,
  output logic [W-1:0] early_root
);
  localparam logic [W-1:0] SAT_LIM = W'(32'h20000);
  localparam logic [W-1:0] SAT_VAL = W'(32'hFFFF8000);

  logic [W-1:0] sum;

  always_comb begin
    sum        = quot + seed;
    early_root = {sig[W-1], sig[W-1:1]};
    if (odd) begin
      z        = (quot << 14) + (seed << 15);
      sig_next = sig >> 1;
      early    = 1'b0;
    end else begin
      z        = (sum >= SAT_LIM) ? SAT_VAL : (sum << 15);
      sig_next = sig;
      early    = (z <= sig);
    end
  end
endmodule

// File: rtl/sqe_div.sv
module sqe_div #(
  parameter int DW = 64,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [VW-1:0] quotient,
  output logic          fin
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [VW-1:0] dvs_q, dvs_d;
  logic          fin_q, fin_d;
  logic          step_en;
  logic [VW:0]   rem_sh;
  logic [VW:0]   diff;
  logic          ge;

  always_comb begin
    step_en = (cnt_q != '0);
    rem_sh  = {rem_q, quo_q[DW-1]};
    diff    = rem_sh - {1'b0, dvs_q};
    ge      = (rem_sh >= {1'b0, dvs_q});
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    fin_d   = 1'b0;
    if (go) begin
      cnt_d = CW'(DW);
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
    end else if (step_en) begin
      cnt_d = cnt_q - CW'(1);
      rem_d = ge ? diff[VW-1:0] : rem_sh[VW-1:0];
      quo_d = {quo_q[DW-2:0], ge};
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      fin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      fin_q <= fin_d;
    end
  end

  assign quotient = quo_q[VW-1:0];
  assign fin      = fin_q;

  assert_divisor_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0));

  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/sig_sqrt_est.sv
module sig_sqrt_est
  import sqe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             exp_odd,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [SIG_W-1:0] root
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  sqe_state_e       st_q, st_d;
  logic [SIG_W-1:0] a_q, a_d;
  logic             odd_q, odd_d;
  logic [SIG_W-1:0] z_q, z_d;
  logic [SIG_W-1:0] root_q, root_d;
  logic             ill_q, ill_d;
  logic             done_q, done_d;

  logic [SIG_W-1:0] seed;
  logic [SIG_W-1:0] ref_z, ref_a, ref_early_root;
  logic             ref_early;
  logic             div_go, div_fin;
  logic [DIV_W-1:0] div_dividend;
  logic [SIG_W-1:0] div_divisor, div_quot;

  sqe_seed #(.W(SIG_W)) u_seed (
    .sig  (a_q),
    .odd  (odd_q),
    .seed (seed)
  );

  sqe_refine #(.W(SIG_W)) u_refine (
    .odd        (odd_q),
    .sig        (a_q),
    .seed       (seed),
    .quot       (div_quot),
    .z          (ref_z),
    .sig_next   (ref_a),
    .early      (ref_early),
    .early_root (ref_early_root)
  );

  always_comb begin
    div_go       = (st_q == ST_GO1) || (st_q == ST_GO2);
    div_dividend = (st_q == ST_GO1) ? {{(DIV_W-SIG_W){1'b0}}, a_q}
                                    : {1'b0, a_q, {(SIG_W-1){1'b0}}};
    div_divisor  = (st_q == ST_GO1) ? seed : z_q;
  end

  sqe_div #(.DW(DIV_W), .VW(SIG_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (div_go),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .quotient (div_quot),
    .fin      (div_fin)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    a_d    = a_q;
    odd_d  = odd_q;
    z_d    = z_q;
    root_d = root_q;
    ill_d  = ill_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (sig_in[SIG_W-1]) begin
            a_d   = sig_in;
            odd_d = exp_odd;
            st_d  = ST_GO1;
          end else begin
            root_d = '0;
            ill_d  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      ST_GO1: st_d = ST_WAIT1;
      ST_WAIT1: begin
        if (div_fin) begin
          z_d = ref_z;
          a_d = ref_a;
          if (ref_early) begin
            root_d = ref_early_root;
            ill_d  = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_GO2;
          end
        end
      end
      ST_GO2: st_d = ST_WAIT2;
      ST_WAIT2: begin
        if (div_fin) begin
          root_d = div_quot + (z_q >> 1);
          ill_d  = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      odd_q  <= 1'b0;
      z_q    <= '0;
      root_q <= '0;
      ill_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      a_q    <= a_d;
      odd_q  <= odd_d;
      z_q    <= z_d;
      root_q <= root_d;
      ill_q  <= ill_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;
  assign root    = root_q;

  assert_illegal_zero_root_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && illegal) |-> (root == '0));

  assert_early_only_even_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st_q == ST_WAIT1) && div_fin && ref_early) |-> !odd_q);

  assert_fin_while_waiting_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    div_fin |-> ((st_q == ST_WAIT1) || (st_q == ST_WAIT2)));

  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);

  assert_root_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done |-> ($stable(root) && $stable(illegal)));
endmodule

// File: tb/sig_sqrt_est_bench.sv
module sig_sqrt_est_bench;
  localparam int LAT_EARLY = 66;
  localparam int LAT_FULL  = 132;
  localparam int WATCHDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] sig_in;
  logic        exp_odd;
  logic        busy, done, illegal;
  logic [31:0] root;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sig_sqrt_est u_sig_sqrt_est (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sig_in  (sig_in),
    .exp_odd (exp_odd),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .root    (root)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] tb_corr(input logic odd, input logic [3:0] i);
    logic [11:0] to [16] = '{12'h004, 12'h022, 12'h05D, 12'h0B1, 12'h11D, 12'h19F, 12'h236, 12'h2E0,
                             12'h39C, 12'h468, 12'h545, 12'h631, 12'h72B, 12'h832, 12'h946, 12'hA67};
    logic [11:0] te [16] = '{12'hA2D, 12'h8AF, 12'h75A, 12'h629, 12'h51A, 12'h429, 12'h356, 12'h29E,
                             12'h200, 12'h179, 12'h109, 12'h0AF, 12'h068, 12'h034, 12'h012, 12'h002};
    return odd ? to[i] : te[i];
  endfunction

  // expected result from the requirement formulas (R2..R5)
  function automatic logic [31:0] model(input logic [31:0] a, input logic odd, output bit early);
    logic [31:0] s, t, z, a2;
    logic [63:0] q;
    early = 1'b0;
    s = (odd ? 32'h4000 : 32'h8000) + (a >> 17) - {20'd0, tb_corr(odd, a[30:27])};
    if (odd) begin
      z  = ((a / s) << 14) + (s << 15);
      a2 = a >> 1;
    end else begin
      t  = a / s + s;
      z  = (t >= 32'h20000) ? 32'hFFFF8000 : (t << 15);
      a2 = a;
      if (z <= a) begin
        early = 1'b1;
        return {a[31], a[31:1]};
      end
    end
    q = ({32'd0, a2} << 31) / {32'd0, z};
    return q[31:0] + (z >> 1);
  endfunction

  task automatic run_op(input logic [31:0] a, input logic odd,
                        output logic [31:0] r, output logic ill, output int lat);
    @(negedge clk);
    sig_in = a; exp_odd = odd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    r = root; ill = illegal;
  endtask

  // legal operand: bit-exact result, real-valued bound, latency, no illegal flag
  task automatic check_legal(input logic [31:0] a, input logic odd, input string req);
    logic [31:0] r, exp_r;
    logic        ill;
    int          lat;
    bit          early;
    real         exact, diff;
    exp_r = model(a, odd, early);
    run_op(a, odd, r, ill, lat);
    exact = odd ? $sqrt(real'(a) * 2147483648.0) : $sqrt(real'(a) * 4294967296.0);
    diff  = real'(r) - exact;
    check(r == exp_r, req, r, exp_r);
    check(diff <= 2.0 && diff >= -2.0, {req, " bound"}, r, longint'(exact));
    check(lat == (early ? LAT_EARLY : LAT_FULL), early ? "R5 latency" : "R6 latency",
          lat, early ? LAT_EARLY : LAT_FULL);
    check(ill == 1'b0, {req, " illegal flag"}, ill, 0);
  endtask

  task automatic t_reset_R9();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 busy/done in reset", {busy, done}, 0);
    check(illegal == 1'b0 && root == 32'd0, "R9 root/illegal in reset", root, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_illegal_R1();
    logic [31:0] r; logic ill; int lat;
    run_op(32'h7FFF_FFFF, 1'b1, r, ill, lat);
    check(ill == 1'b1 && r == 32'd0, "R1 illegal below 2^31", r, 0);
    check(lat == 0, "R1 latency", lat, 0);
    run_op(32'h0000_0000, 1'b0, r, ill, lat);
    check(ill == 1'b1 && r == 32'd0 && lat == 0, "R1 zero operand", r, 0);
    check_legal(32'h8000_0000, 1'b0, "R1 legal clears illegal");
  endtask

  task automatic t_table_index_R2();
    for (int i = 0; i < 16; i++) begin
      check_legal({1'b1, 4'(i), 27'h000_0000}, 1'b1, "R2 odd index");
      check_legal({1'b1, 4'(i), 27'h555_5555}, 1'b0, "R2 even index");
    end
  endtask

  task automatic t_odd_R3();
    logic [31:0] r; logic ill; int lat;
    run_op(32'h8000_0000, 1'b1, r, ill, lat);
    check(r == 32'h8000_0000, "R3 odd 2^31 gives 2^31", r, 32'h8000_0000);
    check_legal(32'hFFFF_FFFF, 1'b1, "R3 odd max");
    check_legal(32'hC000_0001, 1'b1, "R3 odd mid");
  endtask

  task automatic t_even_R4();
    check_legal(32'h8000_0000, 1'b0, "R4 even min");
    check_legal(32'hFFFF_7FFF, 1'b0, "R4 even below early threshold");
    check_legal(32'hA5A5_A5A5, 1'b0, "R4 even mid");
  endtask

  task automatic t_early_R5();
    logic [31:0] r; logic ill; int lat;
    run_op(32'hFFFF_FFFF, 1'b0, r, ill, lat);
    check(r == 32'hFFFF_FFFF, "R5 early max", r, 32'hFFFF_FFFF);
    check(lat == LAT_EARLY, "R5 early latency", lat, LAT_EARLY);
    run_op(32'hFFFF_8000, 1'b0, r, ill, lat);
    check(r == 32'hFFFF_C000, "R5 early threshold", r, 32'hFFFF_C000);
    check(r[31] == 1'b1 && ill == 1'b0, "R5 sign copy", r[31], 1);
  endtask

  task automatic t_busy_R7();
    logic [31:0] exp_r; bit early; int lat;
    exp_r = model(32'h9000_1234, 1'b1, early);
    @(negedge clk);
    sig_in = 32'h9000_1234; exp_odd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    repeat (10) @(negedge clk);
    sig_in = 32'hF000_0000; exp_odd = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 11;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check(root == exp_r, "R7 start while busy ignored", root, exp_r);
    check(lat == LAT_FULL, "R7 latency unchanged", lat, LAT_FULL);
    check(busy == 1'b0, "R7 idle at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done single pulse", done, 0);
  endtask

  task automatic t_hold_R8();
    logic [31:0] r; logic ill; int lat; bit ok;
    run_op(32'hB504_F333, 1'b0, r, ill, lat);
    ok = 1'b1;
    sig_in = 32'h1234_5678;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (root != r || illegal != ill || done) ok = 1'b0;
    end
    check(ok, "R8 root held between completions", root, r);
  endtask

  task automatic t_random();
    for (int k = 0; k < 120; k++) begin
      logic [31:0] a;
      logic        p;
      a = $urandom | 32'h8000_0000;
      p = 1'($urandom);
      check_legal(a, p, p ? "R3 random odd" : "R4 random even");
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    start = 1'b0; sig_in = 32'd0; exp_odd = 1'b0;
    t_reset_R9();
    t_illegal_R1();
    t_odd_R3();
    t_even_R4();
    t_early_R5();
    t_table_index_R2();
    t_busy_R7();
    t_hold_R8();
    t_random();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule